// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates among a large set of numbered interrupt vectors for one processor. Sources post a vector together with its trigger kind, and level sources can later withdraw it. The block tracks which vectors are requested, which are being serviced and which were posted as level-triggered. A task priority value from software and the vector currently in service together set a floor. The block raises a pending line to the processor only when a waiting vector lies in a priority class strictly above that floor.

The processor acknowledges to take the best waiting vector, which is always the highest-numbered requested vector. It signals end-of-interrupt when its handler finishes. A nine-bit spurious register holds a software enable bit above a substitute vector. That substitute vector is returned when the task priority blocks an acknowledge. The acknowledge result is shown on the ports at all times as a preview of what an acknowledge would return. The state moves only on a cycle with the acknowledge strobe. A vector number splits into a class field, which is the upper bits, and a sub-priority field, which is the lowest `CLS_W` bits.

Top module: `vpc_top`

## Requirements
- R1: After reset the request, in-service and trigger arrays and the task priority are all zero, the spurious register holds 0x0FF with the enable (bit 8) clear, `irq_pending` is low, `ppr` is 0 and the acknowledge preview reports `ack_none`.
- R2: A set strobe marks its vector as requested and records its trigger kind (`set_level`=1 level, 0 edge); an acknowledge of that vector reports the recorded kind on `ack_level`.
- R3: A drop strobe clears the request of its vector only when that vector was posted as level-triggered; a drop of an edge-triggered vector has no effect.
- R4: `ppr` equals the task priority when its class (bits 7:4) is greater than or equal to the class of the highest in-service vector (an empty in-service array counts as class 0); otherwise it equals that in-service class with the low four bits zero.
- R5: `irq_pending` is high only when the enable is set, a request exists, and either `ppr` is zero or the class of the highest request is strictly greater than the class of `ppr`.
- R6: With the enable set, a request present and no block under R7, the preview reports `ack_valid` with `ack_vec` equal to the highest-numbered request; an acknowledge moves that vector from requested to in-service.
- R7: When the task priority is nonzero and the highest request is less than or equal to it (full 8-bit compare), the preview reports `ack_spur` with `ack_vec` equal to the low 8 bits of the spurious register; an acknowledge then changes no array.
- R8: With the enable clear or no request present, the preview reports `ack_none` with `ack_vec` 0; an acknowledge then changes no state.
- R9: End-of-interrupt clears only the highest-numbered in-service vector, and does nothing when none is in service.
- R10: A spurious-register write stores all 9 bits; with bit 8 clear `irq_pending` stays low whatever is requested.
- R11: State written at a clock edge is reflected on `irq_pending`, `ppr` and the preview in the cycle right after that edge. Within one cycle a set takes effect after an acknowledge or drop on the same vector, and an acknowledge marks in-service after an end-of-interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 1 | Post a vector request |
| set_vec | input | 8 | Vector to post |
| set_level | input | 1 | Trigger kind of the posted vector, 1 = level |
| drop_req | input | 1 | Level source deasserted |
| drop_vec | input | 8 | Vector whose source deasserted |
| ack_req | input | 1 | Processor acknowledge strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| spv_wr | input | 1 | Spurious register write strobe |
| spv_wdata | input | 9 | Spurious register value, bit 8 = enable |
| irq_pending | output | 1 | Interrupt request to the processor |
| ppr | output | 8 | Current processor priority |
| ack_none | output | 1 | Acknowledge would return nothing |
| ack_spur | output | 1 | Acknowledge would return the spurious vector |
| ack_valid | output | 1 | Acknowledge would return a real vector |
| ack_vec | output | 8 | Vector an acknowledge returns |
| ack_level | output | 1 | Trigger kind of the returned real vector |

## Verification
A corrupted request array shows up within one cycle as a wrong `ack_vec` preview or a wrong pending level. A corrupted in-service array shows up at once in `ppr` and in the pending decision. Trigger-kind errors stay hidden until that vector is acknowledged or dropped. The bench therefore checks the preview before every edge and the pending level and priority after every edge, against a reference model. The stimulus combines a full sweep of all vectors with a long mixed sequence of posts, drops, acknowledges, ends of interrupt and register writes.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
   typedef enum logic [1:0] {
      ACK_NONE = 2'd0,
      ACK_SPUR = 2'd1,
      ACK_REAL = 2'd2
   } ack_kind_e;
endpackage

// File: rtl/vpc_msb_find.sv
module vpc_msb_find #(
   parameter int N    = 256,
   parameter int GRP  = 16,
   parameter bit TREE = 1'b1,
   localparam int IW  = $clog2(N)
) (
   input  logic [N-1:0]  bits,
   output logic          any,
   output logic [IW-1:0] idx
);
   generate
      if (TREE) begin : g_tree
         localparam int GW = $clog2(GRP);
         localparam int NG = N / GRP;
         localparam int SW = IW - GW;
         logic [NG-1:0]  gany;
         logic [SW-1:0]  gsel;
         logic [GW-1:0]  ksel;
         logic [GRP-1:0] slice;
         for (genvar g = 0; g < NG; g++) begin : g_grp
            assign gany[g] = |bits[g*GRP +: GRP];
         end
         always_comb begin
            gsel = '0;
            for (int j = 0; j < NG; j++)
               if (gany[j]) gsel = SW'(j);
            slice = bits[{gsel, {GW{1'b0}}} +: GRP];
            ksel = '0;
            for (int k = 0; k < GRP; k++)
               if (slice[k]) ksel = GW'(k);
         end
         assign any = |gany;
         assign idx = {gsel, ksel};
      end else begin : g_flat
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (bits[i]) idx = IW'(i);
         end
         assign any = |bits;
      end
   endgenerate
endmodule

// File: rtl/vpc_prio.sv
module vpc_prio #(
   parameter int VEC_W = 8,
   parameter int CLS_W = 4,
   localparam int HI_W = VEC_W - CLS_W
) (
   input  logic             en,
   input  logic [VEC_W-1:0] tpr,
   input  logic             isr_any,
   input  logic [HI_W-1:0]  isr_cls,
   input  logic             irr_any,
   input  logic [HI_W-1:0]  irr_cls,
   output logic [VEC_W-1:0] ppr,
   output logic             pending
);
   logic [HI_W-1:0] isr_eff;
   logic [HI_W-1:0] tpr_cls;

   assign isr_eff = isr_any ? isr_cls : '0;
   assign tpr_cls = tpr[VEC_W-1 -: HI_W];
   assign ppr     = (tpr_cls >= isr_eff) ? tpr : {isr_eff, {CLS_W{1'b0}}};
   assign pending = en && irr_any &&
                    ((ppr == '0) || (irr_cls > ppr[VEC_W-1 -: HI_W]));
endmodule

// File: rtl/vpc_top.sv
module vpc_top #(
   parameter int NUM_VEC  = 256,
   parameter int CLS_W    = 4,
   parameter bit TREE_ENC = 1'b1,
   localparam int VEC_W   = $clog2(NUM_VEC),
   localparam int HI_W    = VEC_W - CLS_W,
   localparam int SPV_W   = VEC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_req,
   input  logic [VEC_W-1:0] set_vec,
   input  logic             set_level,
   input  logic             drop_req,
   input  logic [VEC_W-1:0] drop_vec,
   input  logic             ack_req,
   input  logic             eoi_req,
   input  logic             tpr_wr,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             spv_wr,
   input  logic [SPV_W-1:0] spv_wdata,
   output logic             irq_pending,
   output logic [VEC_W-1:0] ppr,
   output logic             ack_none,
   output logic             ack_spur,
   output logic             ack_valid,
   output logic [VEC_W-1:0] ack_vec,
   output logic             ack_level
);
   import vpc_pkg::*;

   if ((NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_num
      $error("NUM_VEC must be a power of two");
   end
   if (HI_W < 1) begin : g_bad_cls
      $error("CLS_W must leave at least one class bit");
   end

   localparam int GRP = 1 << CLS_W;

   logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
   logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;
   logic [VEC_W-1:0]   tpr_q;
   logic [SPV_W-1:0]   spv_q;
   logic               irr_any, isr_any;
   logic [VEC_W-1:0]   irr_top, isr_top;
   ack_kind_e          kind;

   vpc_msb_find #(.N(NUM_VEC), .GRP(GRP), .TREE(TREE_ENC)) u_irr_find (
      .bits(irr_q), .any(irr_any), .idx(irr_top));
   vpc_msb_find #(.N(NUM_VEC), .GRP(GRP), .TREE(TREE_ENC)) u_isr_find (
      .bits(isr_q), .any(isr_any), .idx(isr_top));

   vpc_prio #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_prio (
      .en      (spv_q[VEC_W]),
      .tpr     (tpr_q),
      .isr_any (isr_any),
      .isr_cls (isr_top[VEC_W-1 -: HI_W]),
      .irr_any (irr_any),
      .irr_cls (irr_top[VEC_W-1 -: HI_W]),
      .ppr     (ppr),
      .pending (irq_pending)
   );

   always_comb begin
      if (!spv_q[VEC_W] || !irr_any)                kind = ACK_NONE;
      else if ((tpr_q != '0) && (irr_top <= tpr_q)) kind = ACK_SPUR;
      else                                          kind = ACK_REAL;
   end

   assign ack_none  = (kind == ACK_NONE);
   assign ack_spur  = (kind == ACK_SPUR);
   assign ack_valid = (kind == ACK_REAL);
   assign ack_vec   = ack_valid ? irr_top :
                      ack_spur  ? spv_q[VEC_W-1:0] : '0;
   assign ack_level = ack_valid && tmr_q[irr_top];

   always_comb begin
      irr_n = irr_q;
      isr_n = isr_q;
      tmr_n = tmr_q;
      if (ack_req && ack_valid)          irr_n[irr_top]  = 1'b0;
      if (drop_req && tmr_q[drop_vec])   irr_n[drop_vec] = 1'b0;
      if (set_req) begin
         irr_n[set_vec] = 1'b1;
         tmr_n[set_vec] = set_level;
      end
      if (eoi_req && isr_any)            isr_n[isr_top]  = 1'b0;
      if (ack_req && ack_valid)          isr_n[irr_top]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
         tpr_q <= '0;
         spv_q <= SPV_W'((1 << VEC_W) - 1);
      end else begin
         irr_q <= irr_n;
         isr_q <= isr_n;
         tmr_q <= tmr_n;
         if (tpr_wr) tpr_q <= tpr_wdata;
         if (spv_wr) spv_q <= spv_wdata;
      end
   end

   // assertions
   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> irr_q[$past(set_vec)] && (tmr_q[$past(set_vec)] == $past(set_level)));

   p_drop_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_req && !set_req && tmr_q[drop_vec]) |=> !irr_q[$past(drop_vec)]);

   p_drop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_req && !ack_req && !tmr_q[drop_vec] && irr_q[drop_vec]) |=> irr_q[$past(drop_vec)]);

   p_ack_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ack_valid && !set_req) |=> (isr_q[$past(ack_vec)] && !irr_q[$past(ack_vec)]));

   p_ack_spur_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ack_spur && !set_req && !drop_req && !eoi_req) |=> ($stable(irr_q) && $stable(isr_q)));

   p_ack_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && ack_none && !set_req && !drop_req && !eoi_req) |=> ($stable(irr_q) && $stable(isr_q)));

   p_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_req && !ack_req && isr_any) |=> !isr_q[$past(isr_top)]);

   p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !spv_q[VEC_W] |-> !irq_pending);

   p_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ack_none, ack_spur, ack_valid}) == 1);
endmodule

// File: tb/vpc_top_tb.sv
module vpc_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       set_req = 0, set_level = 0, drop_req = 0, ack_req = 0, eoi_req = 0;
   logic       tpr_wr = 0, spv_wr = 0;
   logic [7:0] set_vec = 0, drop_vec = 0, tpr_wdata = 0;
   logic [8:0] spv_wdata = 0;
   logic       irq_pending, ack_none, ack_spur, ack_valid, ack_level;
   logic [7:0] ppr, ack_vec;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [255:0] m_irr, m_isr, m_tmr;
   logic [7:0]   m_tpr;
   logic [8:0]   m_spv;

   always #2 clk = ~clk;

   vpc_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .set_req(set_req), .set_vec(set_vec), .set_level(set_level),
      .drop_req(drop_req), .drop_vec(drop_vec),
      .ack_req(ack_req), .eoi_req(eoi_req),
      .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
      .spv_wr(spv_wr), .spv_wdata(spv_wdata),
      .irq_pending(irq_pending), .ppr(ppr),
      .ack_none(ack_none), .ack_spur(ack_spur), .ack_valid(ack_valid),
      .ack_vec(ack_vec), .ack_level(ack_level));

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   function automatic int topb(logic [255:0] a);
      int t = -1;
      for (int i = 0; i < 256; i++) if (a[i]) t = i;
      return t;
   endfunction

   function automatic int mppr();
      int ic = topb(m_isr);
      if (ic < 0) ic = 0;
      ic = ic >> 4;
      return ((int'(m_tpr) >> 4) >= ic) ? int'(m_tpr) : (ic << 4);
   endfunction

   function automatic bit mpend();
      int t = topb(m_irr);
      int p = mppr();
      return m_spv[8] && (t >= 0) && ((p == 0) || ((t >> 4) > (p >> 4)));
   endfunction

   // 0 none, 1 spurious, 2 real
   function automatic int mkind();
      int t = topb(m_irr);
      if (!m_spv[8] || t < 0) return 0;
      if (m_tpr != 0 && t <= int'(m_tpr)) return 1;
      return 2;
   endfunction

   task automatic step(string tg, bit s, int sv, bit lv, bit d, int dv,
                       bit a, bit e, bit tw, int td, bit pw, int pd);
      int k, t, et;
      logic [11:0] exp_ack;
      string req;
      @(negedge clk);
      set_req = s; set_vec = 8'(sv); set_level = lv;
      drop_req = d; drop_vec = 8'(dv);
      ack_req = a; eoi_req = e;
      tpr_wr = tw; tpr_wdata = 8'(td);
      spv_wr = pw; spv_wdata = 9'(pd);
      #1;
      k = mkind();
      t = topb(m_irr);
      et = topb(m_isr);
      if (k == 0)      begin exp_ack = {4'b1000, 8'h00};                req = "R8"; end
      else if (k == 1) begin exp_ack = {4'b0100, m_spv[7:0]};           req = "R7"; end
      else             begin exp_ack = {3'b001, m_tmr[t], 8'(t)};       req = "R6"; end
      if (tg != "") req = tg;
      chk({req, " ack preview"},
          {20'd0, ack_none, ack_spur, ack_valid, ack_level, ack_vec}, {20'd0, exp_ack});
      @(posedge clk);
      #1;
      set_req = 0; drop_req = 0; ack_req = 0; eoi_req = 0; tpr_wr = 0; spv_wr = 0;
      if (a && k == 2) m_irr[t] = 1'b0;
      if (d && m_tmr[dv]) m_irr[dv] = 1'b0;
      if (s) begin m_irr[sv] = 1'b1; m_tmr[sv] = lv; end
      if (e && et >= 0) m_isr[et] = 1'b0;
      if (a && k == 2) m_isr[t] = 1'b1;
      if (tw) m_tpr = 8'(td);
      if (pw) m_spv = 9'(pd);
      chk("R5/R11 pending", {31'd0, irq_pending}, {31'd0, mpend()});
      chk("R4 ppr", {24'd0, ppr}, 32'(mppr()));
   endtask

   task automatic idle(string tg);
      step(tg, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = 0; m_spv = 9'h0FF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset pending", {31'd0, irq_pending}, 0);
      chk("R1 reset ppr", {24'd0, ppr}, 0);
      chk("R1 reset ack_none", {31'd0, ack_none}, 1);
      rst_n = 1'b1;
      idle("R1");

      // R10: disabled controller ignores requests at the pending line
      step("R10", 1, 8'h90, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R10 disabled pending", {31'd0, irq_pending}, 0);
      step("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R8 disabled ack keeps request", {31'd0, irq_pending}, 0);
      step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9'h1A5);
      chk("R10 enabled pending", {31'd0, irq_pending}, 1);
      step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      chk("R9 eoi empties service", {24'd0, ppr}, 0);

      // full sweep: every vector posted, acknowledged and retired
      for (int v = 0; v < 256; v++) begin
         step("R2", 1, v, v[0], 0, 0, 0, 0, 0, 0, 0, 0);
         step("R2", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
         step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      end

      // R3: drop clears a level vector, ignored for an edge vector
      step("", 1, 8'h77, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 8'h77, 0, 0, 0, 0, 0, 0);
      chk("R3 level drop", {31'd0, ack_none}, 1);
      step("", 1, 8'h66, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 0, 1, 8'h66, 0, 0, 0, 0, 0, 0);
      chk("R3 edge drop ignored", {24'd0, ack_vec}, 32'h66);
      step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

      // R7 / R4: task priority blocking and class equality corner
      step("", 0, 0, 0, 0, 0, 0, 0, 1, 8'h40, 0, 0);
      step("", 1, 8'h43, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R5 same class not pending", {31'd0, irq_pending}, 0);
      step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 8'h20, 0, 0);
      chk("R4 isr class dominates", {24'd0, ppr}, 32'h40);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 1, 8'h40, 0, 0);
      step("", 1, 8'h40, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R7 spurious vector", {24'd0, ack_vec}, 32'hA5);
      step("R7", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R7 request kept", {31'd0, ack_spur}, 1);
      step("", 0, 0, 0, 1, 8'h40, 0, 0, 1, 0, 0, 0);

      // R9 nesting: eoi retires only the highest in-service vector
      step("", 1, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("", 1, 8'h50, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R9 nested ppr", {24'd0, ppr}, 32'h50);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      chk("R9 lower remains", {24'd0, ppr}, 32'h20);
      step("R9", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
      // R11: set and ack of the same vector in one cycle, set wins
      step("", 1, 8'h31, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      step("R11", 1, 8'h31, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      chk("R11 set after ack", {31'd0, ack_valid}, 1);

      // mixed sequence against the model
      for (int n = 0; n < 4000; n++) begin
         int op = $urandom % 8;
         int v = (($urandom % 4) == 0) ? ($urandom % 256) : (8'h30 + ($urandom % 64));
         case (op)
            0, 1: step("", 1, v, $urandom % 2, 0, 0, 0, 0, 0, 0, 0, 0);
            2: step("", 0, 0, 0, 1, v, 0, 0, 0, 0, 0, 0);
            3, 4: step("", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
            5: step("", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
            6: step("", 0, 0, 0, 0, 0, 0, 0, 1, (($urandom % 8) << 4) | ($urandom % 16), 0, 0);
            default: step("", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1,
                          ((($urandom % 8) != 0) ? 9'h100 : 9'h000) | ($urandom % 256));
         endcase
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule